// File: doc/BRIEF.md
# Multi-Bank Rename Temporary Tracker

This block decides whether an instruction may dispatch. The deciding resource is the supply of rename temporaries held in a set of physical register banks. Every physical register carries a bank-membership mask, and bit i of that mask places the register in bank i. Banks may overlap, so one destination write can need a temporary from several banks at the same time. Bank 0 always holds every register.

A request presents up to four destination registers. In the same cycle the block forms a demand per bank and returns a per-bank stall mask. When the request is valid, the dispatch input is high and the mask is all zero, the block grants dispatch and reserves temporaries at the next clock edge. Retiring writes release their temporaries through a separate port. Each bank keeps the following state:
- its capacity
- its used count
- its peak used count
- a running total of reserved temporaries
- a sticky warning flag
- a sticky error flag

A single counter records every cycle that stalls. A bank index selects which bank's values appear on the statistics outputs.

Top module: `rtb_tracker`

## Requirements
- R1: A mask write stores the given value for the selected register, with bit 0 (bank 0) always forced to 1. After that, a reservation of the register also counts in bank 0 even if the written value had bit 0 clear.
- R2: For a request, the demand of bank i equals the number of destination slots whose valid bit is set and whose register mask has bit i set.
- R3: The stall bit i is 1 only when all of the following hold: `req_vld` is high, bank i demand is nonzero, bank i capacity is nonzero, and used count plus demand exceeds the effective capacity. A bank with capacity 0 never stalls. The mask is combinational in the same cycle.
- R4: When a valid request has a nonzero demand in a bank with nonzero capacity, and that demand is larger than the capacity, the effective capacity for the comparison equals the demand. At the next edge the capacity becomes the demand and that bank's sticky warning bit is set.
- R5: `disp_ok` is high when `req_vld` and `disp_go` are high and the stall mask is zero. Every bank then adds its demand to both its used count and its total count at the next edge. In every other case no reservation happens.
- R6: The peak count of a bank is the maximum of the old peak and the new used count.
- R7: A release lowers the used count of every bank in the released register's mask by one. If a bank's release count exceeds its used count plus its reservation in that cycle, the used count becomes 0 and that bank's sticky error bit is set.
- R8: A reservation and a release in the same cycle in the same bank change the used count by their difference.
- R9: `stall_cnt` increments by one in each cycle in which the stall mask is nonzero, whichever banks caused it, and holds otherwise.
- R10: The statistics outputs show the values of the bank chosen by `stat_sel`, combinationally. Reset clears used, peak, total, flags and the stall counter, but keeps the capacities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Write strobe for a register's bank mask |
| map_reg | input | 6 | Register whose mask is written |
| map_val | input | 4 | Bank mask value (bit 0 forced to 1) |
| cap_we | input | 1 | Write strobe for a bank capacity |
| cap_sel | input | 2 | Bank whose capacity is written |
| cap_val | input | 8 | Capacity value, 0 means unbounded |
| req_vld | input | 1 | Request present |
| req_dst_vld | input | 4 | Valid bit per destination slot |
| req_dst | input | 24 | Destination registers, slot k at bits 6k+5:6k |
| disp_go | input | 1 | Dispatch wanted for the current request |
| rel_vld | input | 4 | Valid bit per release slot |
| rel_dst | input | 24 | Released registers, slot k at bits 6k+5:6k |
| stall_mask | output | 4 | Per-bank stall response |
| disp_ok | output | 1 | Dispatch granted, reservation occurs at next edge |
| stat_sel | input | 2 | Bank shown on the statistics outputs |
| stat_cap | output | 8 | Capacity of the selected bank |
| stat_used | output | 8 | Used count of the selected bank |
| stat_peak | output | 8 | Peak used count of the selected bank |
| stat_total | output | 16 | Total temporaries reserved in the selected bank |
| warn_flags | output | 4 | Sticky per-bank capacity-raised flags |
| err_flags | output | 4 | Sticky per-bank release-underflow flags |
| stall_cnt | output | 16 | Count of stalled cycles |

## Verification
The stall mask and `disp_ok` depend on the current inputs in the same cycle. The bench drives inputs on the falling edge and compares these two outputs 0.5 ns later, before the next rising edge. Capacity, used, peak, total, the flags and the stall counter change on the rising edge that follows the stimulus, so the bench updates its arithmetic model at that edge. Starting 0.5 ns after the edge, it steps `stat_sel` through all four banks and compares each one. A long pseudo-random sweep, broken up by resets, is preceded by directed sequences for the zero-capacity bank, the forced bank-0 bit, capacity raising, underflow and the same-cycle reserve/release case.

// File: rtl/rtb_pkg.sv
`timescale 1ns/1ps
package rtb_pkg;

  // Index width for a table of n entries (at least one bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Width able to hold the values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rtb_mask_table.sv
`timescale 1ns/1ps
module rtb_mask_table #(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned NREG   = 64,
  parameter int unsigned NRD    = 8,
  parameter int unsigned RIDX_W = 6
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [RIDX_W-1:0]       wr_idx,
  input  logic [NBANK-1:0]        wr_mask,
  input  logic [NRD*RIDX_W-1:0]   rd_idx,
  output logic [NRD*NBANK-1:0]    rd_mask
);

  // Configuration storage: survives reset on purpose.
  logic [NBANK-1:0] mem_q [NREG];
  logic [NBANK-1:0] wr_word;

  // Bank 0 holds every register, so its bit is always forced on.
  always_comb wr_word = wr_mask | NBANK'(1);

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_word;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_mask[k*NBANK +: NBANK] = mem_q[rd_idx[k*RIDX_W +: RIDX_W]];
  end

endmodule

// File: rtl/rtb_demand.sv
`timescale 1ns/1ps
module rtb_demand #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned NDST  = 4,
  parameter int unsigned DEM_W = 3
) (
  input  logic [NDST-1:0]        slot_vld,
  input  logic [NDST*NBANK-1:0]  slot_mask,
  output logic [NBANK*DEM_W-1:0] demand
);

  // One population counter per bank over the valid slots.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DEM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int d = 0; d < NDST; d++) begin
        if (slot_vld[d] && slot_mask[d*NBANK + b]) acc = acc + DEM_W'(1);
      end
    end
    assign demand[b*DEM_W +: DEM_W] = acc;
  end

endmodule

// File: rtl/rtb_bank.sv
`timescale 1ns/1ps
module rtb_bank #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEM_W  = 3,
  parameter int unsigned STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_val,
  input  logic              req_vld,
  input  logic [DEM_W-1:0]  dem_req,
  input  logic              fire,
  input  logic [DEM_W-1:0]  dem_rel,
  output logic              stall,
  output logic [CNT_W-1:0]  cap,
  output logic [CNT_W-1:0]  used,
  output logic [CNT_W-1:0]  peak,
  output logic [STAT_W-1:0] total,
  output logic              warn,
  output logic              err
);

  localparam int unsigned XW = CNT_W + 1;

  logic [CNT_W-1:0]  cap_q, cap_d, used_q, used_d, peak_q, peak_d;
  logic [STAT_W-1:0] total_q, total_d;
  logic              warn_q, warn_d, err_q, err_d;
  logic              cap_en, cnt_en;
  logic [XW-1:0]     dem_x, eff_x, need_x, inc_x, rel_x, sum_x;
  logic              bounded, active, raise, under;

  // Availability check for the current request.
  always_comb begin
    dem_x   = XW'(dem_req);
    bounded = (cap_q != '0);
    active  = req_vld && (dem_req != '0) && bounded;
    raise   = active && (dem_x > {1'b0, cap_q});
    eff_x   = raise ? dem_x : {1'b0, cap_q};
    need_x  = {1'b0, used_q} + dem_x;
    stall   = active && (need_x > eff_x);
  end

  // Next state of the counters.
  always_comb begin
    inc_x   = fire ? dem_x : '0;
    rel_x   = XW'(dem_rel);
    sum_x   = {1'b0, used_q} + inc_x;
    under   = (rel_x > sum_x);
    used_d  = under ? '0 : CNT_W'(sum_x - rel_x);
    peak_d  = (used_d > peak_q) ? used_d : peak_q;
    total_d = total_q + STAT_W'(inc_x);
    cnt_en  = (inc_x != '0) || (rel_x != '0);
    warn_d  = warn_q | raise;
    err_d   = err_q | under;
    cap_en  = cfg_we || raise;
    cap_d   = cfg_we ? cfg_val : CNT_W'(dem_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q  <= '0;
      peak_q  <= '0;
      total_q <= '0;
      warn_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cnt_en) begin
        used_q  <= used_d;
        peak_q  <= peak_d;
        total_q <= total_d;
      end
      warn_q <= warn_d;
      err_q  <= err_d;
    end
  end

  // Capacity is configuration: no reset.
  always_ff @(posedge clk) begin
    if (cap_en) cap_q <= cap_d;
  end

  assign cap   = cap_q;
  assign used  = used_q;
  assign peak  = peak_q;
  assign total = total_q;
  assign warn  = warn_q;
  assign err   = err_q;

endmodule

// File: rtl/rtb_tracker.sv
`timescale 1ns/1ps
module rtb_tracker
  import rtb_pkg::*;
#(
  parameter  int unsigned NBANK  = 4,
  parameter  int unsigned NREG   = 64,
  parameter  int unsigned NDST   = 4,
  parameter  int unsigned CNT_W  = 8,
  parameter  int unsigned STAT_W = 16,
  parameter  int unsigned SC_W   = 16,
  localparam int unsigned RIDX_W = idx_width(NREG),
  localparam int unsigned BIDX_W = idx_width(NBANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   map_we,
  input  logic [RIDX_W-1:0]      map_reg,
  input  logic [NBANK-1:0]       map_val,
  input  logic                   cap_we,
  input  logic [BIDX_W-1:0]      cap_sel,
  input  logic [CNT_W-1:0]       cap_val,
  input  logic                   req_vld,
  input  logic [NDST-1:0]        req_dst_vld,
  input  logic [NDST*RIDX_W-1:0] req_dst,
  input  logic                   disp_go,
  input  logic [NDST-1:0]        rel_vld,
  input  logic [NDST*RIDX_W-1:0] rel_dst,
  output logic [NBANK-1:0]       stall_mask,
  output logic                   disp_ok,
  input  logic [BIDX_W-1:0]      stat_sel,
  output logic [CNT_W-1:0]       stat_cap,
  output logic [CNT_W-1:0]       stat_used,
  output logic [CNT_W-1:0]       stat_peak,
  output logic [STAT_W-1:0]      stat_total,
  output logic [NBANK-1:0]       warn_flags,
  output logic [NBANK-1:0]       err_flags,
  output logic [SC_W-1:0]        stall_cnt
);

  localparam int unsigned DEM_W = cnt_width(NDST);
  localparam int unsigned NRD   = 2 * NDST;

  logic [NRD*NBANK-1:0]   rd_mask;
  logic [NBANK*DEM_W-1:0] dem_req, dem_rel;
  logic                   fire;

  logic [CNT_W-1:0]  cap_arr   [NBANK];
  logic [CNT_W-1:0]  used_arr  [NBANK];
  logic [CNT_W-1:0]  peak_arr  [NBANK];
  logic [STAT_W-1:0] total_arr [NBANK];
  logic [NBANK*CNT_W-1:0] cap_flat, used_flat;

  logic [SC_W-1:0] sc_q, sc_d;
  logic            sc_en;

  // Request slots occupy the low read ports, release slots the high ones.
  rtb_mask_table #(
    .NBANK(NBANK), .NREG(NREG), .NRD(NRD), .RIDX_W(RIDX_W)
  ) u_map (
    .clk    (clk),
    .wr_en  (map_we),
    .wr_idx (map_reg),
    .wr_mask(map_val),
    .rd_idx ({rel_dst, req_dst}),
    .rd_mask(rd_mask)
  );

  rtb_demand #(.NBANK(NBANK), .NDST(NDST), .DEM_W(DEM_W)) u_dem_req (
    .slot_vld (req_dst_vld),
    .slot_mask(rd_mask[NDST*NBANK-1:0]),
    .demand   (dem_req)
  );

  rtb_demand #(.NBANK(NBANK), .NDST(NDST), .DEM_W(DEM_W)) u_dem_rel (
    .slot_vld (rel_vld),
    .slot_mask(rd_mask[NRD*NBANK-1:NDST*NBANK]),
    .demand   (dem_rel)
  );

  assign fire    = req_vld && disp_go && (stall_mask == '0);
  assign disp_ok = fire;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rtb_bank #(.CNT_W(CNT_W), .DEM_W(DEM_W), .STAT_W(STAT_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (cap_we && (cap_sel == BIDX_W'(b))),
      .cfg_val(cap_val),
      .req_vld(req_vld),
      .dem_req(dem_req[b*DEM_W +: DEM_W]),
      .fire   (fire),
      .dem_rel(dem_rel[b*DEM_W +: DEM_W]),
      .stall  (stall_mask[b]),
      .cap    (cap_arr[b]),
      .used   (used_arr[b]),
      .peak   (peak_arr[b]),
      .total  (total_arr[b]),
      .warn   (warn_flags[b]),
      .err    (err_flags[b])
    );
    assign cap_flat[b*CNT_W +: CNT_W]  = cap_arr[b];
    assign used_flat[b*CNT_W +: CNT_W] = used_arr[b];
  end

  // Shared stall counter.
  always_comb begin
    sc_en = (stall_mask != '0);
    sc_d  = sc_q + SC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sc_q <= '0;
    else if (sc_en) sc_q <= sc_d;
  end

  assign stall_cnt  = sc_q;
  assign stat_cap   = cap_arr[stat_sel];
  assign stat_used  = used_arr[stat_sel];
  assign stat_peak  = peak_arr[stat_sel];
  assign stat_total = total_arr[stat_sel];

endmodule

// File: rtl/rtb_tracker_chk.sv
`timescale 1ns/1ps
module rtb_tracker_chk #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned NDST  = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SC_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_vld,
  input logic [NDST-1:0]        rel_vld,
  input logic [NBANK-1:0]       stall_mask,
  input logic                   disp_ok,
  input logic [SC_W-1:0]        stall_cnt,
  input logic [NBANK-1:0]       err_flags,
  input logic [NBANK-1:0]       warn_flags,
  input logic [CNT_W-1:0]       stat_used,
  input logic [CNT_W-1:0]       stat_peak,
  input logic [NBANK*CNT_W-1:0] cap_flat,
  input logic [NBANK*CNT_W-1:0] used_flat
);

  p_idle_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> (stall_mask == '0));

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    p_unbounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flat[b*CNT_W +: CNT_W] == '0) |-> !stall_mask[b]);
  end

  p_stall_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mask != '0) |=> (stall_cnt == $past(stall_cnt) + 1'b1));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_mask == '0) |=> $stable(stall_cnt));

  p_no_grant_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ok && (rel_vld == '0)) |=> $stable(used_flat));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_warn_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((warn_flags & $past(warn_flags)) == $past(warn_flags)));

  p_peak_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> (stat_peak >= stat_used));

endmodule

bind rtb_tracker rtb_tracker_chk #(
  .NBANK(NBANK), .NDST(NDST), .CNT_W(CNT_W), .SC_W(SC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .rel_vld   (rel_vld),
  .stall_mask(stall_mask),
  .disp_ok   (disp_ok),
  .stall_cnt (stall_cnt),
  .err_flags (err_flags),
  .warn_flags(warn_flags),
  .stat_used (stat_used),
  .stat_peak (stat_peak),
  .cap_flat  (cap_flat),
  .used_flat (used_flat)
);

// File: tb/sim_rtb_tracker.sv
`timescale 1ns/1ps
module sim_rtb_tracker;
  localparam int NB = 4, NR = 64, ND = 4, CW = 8, SW = 16, CCW = 16, RW = 6, BW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, map_we, cap_we, req_vld, disp_go;
  logic [RW-1:0]   map_reg;
  logic [NB-1:0]   map_val;
  logic [BW-1:0]   cap_sel, stat_sel;
  logic [CW-1:0]   cap_val;
  logic [ND-1:0]   req_dst_vld, rel_vld;
  logic [ND*RW-1:0] req_dst, rel_dst;
  logic [NB-1:0]   stall_mask, warn_flags, err_flags;
  logic            disp_ok;
  logic [CW-1:0]   stat_cap, stat_used, stat_peak;
  logic [SW-1:0]   stat_total;
  logic [CCW-1:0]  stall_cnt;

  rtb_tracker #(.NBANK(NB), .NREG(NR), .NDST(ND), .CNT_W(CW), .STAT_W(SW), .SC_W(CCW)) u0 (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_reg(map_reg), .map_val(map_val),
    .cap_we(cap_we), .cap_sel(cap_sel), .cap_val(cap_val), .req_vld(req_vld),
    .req_dst_vld(req_dst_vld), .req_dst(req_dst), .disp_go(disp_go),
    .rel_vld(rel_vld), .rel_dst(rel_dst), .stall_mask(stall_mask), .disp_ok(disp_ok),
    .stat_sel(stat_sel), .stat_cap(stat_cap), .stat_used(stat_used),
    .stat_peak(stat_peak), .stat_total(stat_total), .warn_flags(warn_flags),
    .err_flags(err_flags), .stall_cnt(stall_cnt)
  );

  int n_chk = 0, n_err = 0;

  // Arithmetic model
  logic [NB-1:0] m_mask [NR];
  int            m_cap [NB], m_used [NB], m_peak [NB], m_total [NB];
  int            dem_r [NB], dem_l [NB];
  logic [NB-1:0] m_warn, m_err, m_stall;
  logic          m_fire;
  int            m_scnt;
  logic [31:0]   lf = 32'h1234_5678;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  task automatic idle();
    map_we = 0; cap_we = 0; req_vld = 0; disp_go = 0;
    req_dst_vld = '0; rel_vld = '0; req_dst = '0; rel_dst = '0;
  endtask

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      m_used[b] = 0; m_peak[b] = 0; m_total[b] = 0;
    end
    m_warn = '0; m_err = '0; m_scnt = 0;
  endtask

  task automatic model_eval();
    int eff;
    for (int b = 0; b < NB; b++) begin dem_r[b] = 0; dem_l[b] = 0; end
    for (int d = 0; d < ND; d++)
      for (int b = 0; b < NB; b++) begin
        if (req_dst_vld[d] && m_mask[req_dst[d*RW +: RW]][b]) dem_r[b]++;
        if (rel_vld[d] && m_mask[rel_dst[d*RW +: RW]][b]) dem_l[b]++;
      end
    m_stall = '0;
    for (int b = 0; b < NB; b++) begin
      if (req_vld && dem_r[b] != 0 && m_cap[b] != 0) begin
        eff = (dem_r[b] > m_cap[b]) ? dem_r[b] : m_cap[b];
        if (m_used[b] + dem_r[b] > eff) m_stall[b] = 1'b1;
      end
    end
    m_fire = req_vld && disp_go && (m_stall == '0);
  endtask

  task automatic model_commit();
    int inc, sum;
    for (int b = 0; b < NB; b++) begin
      if (req_vld && dem_r[b] != 0 && m_cap[b] != 0 && dem_r[b] > m_cap[b]) begin
        m_cap[b] = dem_r[b]; m_warn[b] = 1'b1;
      end
      inc = m_fire ? dem_r[b] : 0;
      sum = m_used[b] + inc;
      if (dem_l[b] > sum) begin m_err[b] = 1'b1; m_used[b] = 0; end
      else m_used[b] = sum - dem_l[b];
      if (m_used[b] > m_peak[b]) m_peak[b] = m_used[b];
      m_total[b] = (m_total[b] + inc) % 65536;
    end
    if (m_stall != '0) m_scnt = (m_scnt + 1) % 65536;
  endtask

  // Registered results: sampled just after the rising edge.
  task automatic check_all();
    for (int b = 0; b < NB; b++) begin
      stat_sel = BW'(b);
      #0.2;
      chk("R4 R10", $sformatf("cap[%0d]", b), stat_cap, m_cap[b]);
      chk("R5 R7 R8", $sformatf("used[%0d]", b), stat_used, m_used[b]);
      chk("R6", $sformatf("peak[%0d]", b), stat_peak, m_peak[b]);
      chk("R5", $sformatf("total[%0d]", b), stat_total, m_total[b]);
    end
    chk("R4", "warn_flags", warn_flags, m_warn);
    chk("R7", "err_flags", err_flags, m_err);
    chk("R9", "stall_cnt", stall_cnt, m_scnt);
  endtask

  // Called right after the falling edge with the inputs already driven.
  task automatic step();
    model_eval();
    #0.5;
    chk("R2 R3", "stall_mask", stall_mask, m_stall);
    chk("R5", "disp_ok", disp_ok, m_fire);
    @(posedge clk);
    model_commit();
    #0.5;
    check_all();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    model_clear();
    @(posedge clk); #0.5; check_all(); @(negedge clk);
  endtask

  task automatic set_cap(input int b, input int v);
    cap_we = 1; cap_sel = BW'(b); cap_val = CW'(v);
    @(posedge clk); #0.5; cap_we = 0; m_cap[b] = v; @(negedge clk);
  endtask

  task automatic set_mask(input int r, input logic [NB-1:0] v);
    map_we = 1; map_reg = RW'(r); map_val = v;
    @(posedge clk); #0.5; map_we = 0; m_mask[r] = v | NB'(1); @(negedge clk);
  endtask

  task automatic put_req(input int k, input int r);
    req_dst[k*RW +: RW] = RW'(r); req_dst_vld[k] = 1'b1;
  endtask

  task automatic put_rel(input int k, input int r);
    rel_dst[k*RW +: RW] = RW'(r); rel_vld[k] = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin : main
    int sel [3];
    int n;
    idle(); stat_sel = '0; map_reg = '0; map_val = '0; cap_sel = '0; cap_val = '0;
    rst_n = 0;
    @(negedge clk);
    set_cap(0, 0); set_cap(1, 3); set_cap(2, 4); set_cap(3, 2);
    for (int r = 0; r < NR; r++) set_mask(r, NB'((r * 5 + 2) & 15));
    rst_n = 1;
    model_clear();
    @(posedge clk); #0.5;
    check_all();                                   // R10 reset state
    @(negedge clk);

    // R3: capacity 0 in bank 0 never stalls
    req_vld = 1; put_req(0, 1); put_req(1, 2); put_req(2, 3); put_req(3, 4);
    #0.5; chk("R3", "unbounded bank0 stall", stall_mask[0], 0);
    step();

    // R1: written mask without bit 0 still counts in bank 0
    set_mask(10, 4'b1000);
    req_vld = 1; disp_go = 1; put_req(0, 10);
    step();
    stat_sel = 0; #0.2; chk("R1", "bank0 used after reserve", stat_used, 1);
    put_rel(0, 10); step();

    // R7: release from empty banks
    put_rel(0, 10); step();
    chk("R7", "err after empty release", err_flags, 4'b1001);
    stat_sel = 3; #0.2; chk("R7", "bank3 used clamps", stat_used, 0);
    @(negedge clk);

    // R10: reset keeps capacities
    do_reset();
    stat_sel = 3; #0.2; chk("R10", "cap kept over reset", stat_cap, 2);
    @(negedge clk);

    // R4: three bank-3 writes against capacity 2
    n = 0;
    for (int r = 0; r < NR && n < 3; r++) if (m_mask[r][3] && !m_mask[r][1]) begin sel[n] = r; n++; end
    req_vld = 1; disp_go = 1;
    for (int k = 0; k < 3; k++) put_req(k, sel[k]);
    step();
    chk("R4", "warn bank3", warn_flags[3], 1);
    stat_sel = 3; #0.2; chk("R4", "bank3 raised cap", stat_cap, 3);
    @(negedge clk);
    for (int k = 0; k < 3; k++) put_rel(k, sel[k]);
    step();

    // R8: same-cycle reserve and release
    req_vld = 1; disp_go = 1; put_req(0, 20); step();
    req_vld = 1; disp_go = 1; put_req(0, 21); put_rel(0, 20); step();
    stat_sel = 0; #0.2;
    chk("R8", "bank0 used net zero", stat_used, 1);
    chk("R8", "bank0 total", stat_total, 5);
    @(negedge clk);
    put_rel(0, 21); step();

    // Sweep with bounded banks and periodic resets
    set_cap(0, 6); set_cap(1, 3); set_cap(2, 4); set_cap(3, 2);
    do_reset();
    for (int i = 0; i < 2400; i++) begin
      logic [31:0] v, w;
      v = rnd(); w = rnd();
      req_vld = v[0]; disp_go = v[1] | v[2];
      for (int k = 0; k < ND; k++) begin
        req_dst[k*RW +: RW] = v[8+k*6 +: 6];
        req_dst_vld[k] = v[3+k] & ~w[28+k];
        rel_dst[k*RW +: RW] = w[k*6 +: 6];
        rel_vld[k] = (w[24+k] & w[20+k]);
      end
      step();
      if (i % 600 == 599) begin
        do_reset();
        set_cap(3, 2);
      end
    end

    summary();
    $finish;
  end

endmodule